// File: doc/BRIEF.md
# ECC-Based DIMM Half Resolver

Once an error address has been matched to a chip-select, this block decides which DIMM of a paired chip-select holds the fault. Its inputs are the DIMM count on that chip-select, the ECC organisation and the fault information. The organisation is either per-half 64/8 or symbol-based. The fault information is address bit 3, the index of the lowest address bit known to be valid, a correctable flag, and an already-decoded symbol description: whether the decode succeeded, whether the symbol covers data or check bits, and the symbol's highest bit index.

In per-half mode each 64-bit half carries its own check bits, so even an uncorrectable fault stays in one half. The block then places the fault from the address, provided the address is precise enough. In symbol mode a correctable fault is placed from the symbol's bit position. An uncorrectable fault cannot be placed, and the block names both DIMMs. Each request gives a 2-bit DIMM mask or an error code, one cycle later, qualified by a valid strobe.

Top module: `dimm_half_resolver`

## Requirements
- R1: With a DIMM count of 0 the result carries error code 1 (no DIMM) and mask 0.
- R2: With a DIMM count of 1 the mask is 2'b01 (bit0 = low DIMM) and the error code is 0, whatever the other inputs are.
- R3: With two or more DIMMs, per-half mode (ecc_sym = 0) and a lowest valid bit index of 3 or less, the mask is 2'b10 (bit1 = upper DIMM) when addr_b3 is 1 and 2'b01 when it is 0. The correctable flag and the symbol inputs have no effect.
- R4: With two or more DIMMs in per-half mode and a lowest valid bit index above 3, the error code is 2 (insufficient resolution).
- R5: With two or more DIMMs, symbol mode (ecc_sym = 1), a correctable fault and a decoded symbol, the mask is 2'b01 when the symbol is a data symbol with high bit at most 63. It is also 2'b01 when the symbol is a check symbol with high bit at most 7. Otherwise it is 2'b10.
- R6: With two or more DIMMs in symbol mode and an uncorrectable fault, the mask is 2'b11 whether or not the symbol decoded.
- R7: With two or more DIMMs in symbol mode, a correctable fault and a failed symbol decode, the error code is 3 (invalid symbol).
- R8: res_valid is high exactly in the cycle after a cycle with req_valid high. While res_valid is low, the mask and error code read 0.
- R9: Whenever the error code is nonzero, the mask is 0.
- R10: After reset res_valid, the mask and the error code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| dimm_cnt | input | 2 | DIMMs on the matched chip-select |
| ecc_sym | input | 1 | 0 = per-half 64/8 ECC, 1 = symbol ECC |
| addr_b3 | input | 1 | Address bit 3 |
| low_valid_idx | input | IDX_W | Index of lowest valid address bit |
| correctable | input | 1 | Fault is correctable |
| sym_ok | input | 1 | Symbol decoded successfully |
| sym_is_data | input | 1 | Symbol covers data bits (0 = check bits) |
| sym_hi_bit | input | HI_W | Highest bit index covered by the symbol |
| res_valid | output | 1 | Result strobe |
| dimm_mask | output | 2 | bit0 low DIMM, bit1 upper DIMM |
| err_code | output | 2 | 0 ok, 1 no DIMM, 2 insufficient resolution, 3 invalid symbol |

## Verification
The assertions take for granted that the request fields are stable while req_valid is high. They also assume the symbol description means something only when sym_ok is set. For that reason no property constrains the mask from the symbol fields unless the fault is correctable and decoded. The stimulus drives a complete request in the cycle before each strobe and then idles for a cycle. The sweep covers every DIMM count, mode, flag and valid-bit index from 0 to 7. High-bit values sit on both sides of the 7 and 63 limits, so every input combination the assertions rely on is legal.

// File: rtl/dhr_pkg.sv
package dhr_pkg;
   typedef enum logic [1:0] {
      DHR_OK      = 2'd0,
      DHR_NO_DIMM = 2'd1,
      DHR_LOW_RES = 2'd2,
      DHR_BAD_SYM = 2'd3
   } dhr_err_e;

   localparam logic [1:0] MASK_NONE = 2'b00;
   localparam logic [1:0] MASK_LOW  = 2'b01;
   localparam logic [1:0] MASK_UP   = 2'b10;
   localparam logic [1:0] MASK_BOTH = 2'b11;
endpackage

// File: rtl/dhr_half_pick.sv
module dhr_half_pick
   import dhr_pkg::*;
#(
   parameter int IDX_W   = 6,
   parameter int RES_LSB = 3
) (
   input  logic             addr_b3,
   input  logic [IDX_W-1:0] low_valid_idx,
   output logic [1:0]       mask,
   output dhr_err_e         err
);
   if (RES_LSB >= (1 << IDX_W)) begin : g_bad_res
      $error("RES_LSB does not fit in IDX_W");
   end

   localparam logic [IDX_W-1:0] RES_LIM = IDX_W'(RES_LSB);

   always_comb begin
      if (low_valid_idx <= RES_LIM) begin
         mask = addr_b3 ? MASK_UP : MASK_LOW;
         err  = DHR_OK;
      end else begin
         mask = MASK_NONE;
         err  = DHR_LOW_RES;
      end
   end
endmodule

// File: rtl/dhr_sym_pick.sv
module dhr_sym_pick
   import dhr_pkg::*;
#(
   parameter int HI_W      = 8,
   parameter int DATA_TOP  = 63,
   parameter int CHECK_TOP = 7
) (
   input  logic            correctable,
   input  logic            sym_ok,
   input  logic            sym_is_data,
   input  logic [HI_W-1:0] sym_hi_bit,
   output logic [1:0]      mask,
   output dhr_err_e        err
);
   if (DATA_TOP >= (1 << HI_W) || CHECK_TOP >= (1 << HI_W)) begin : g_bad_top
      $error("half limits do not fit in HI_W");
   end

   localparam logic [HI_W-1:0] DATA_LIM  = HI_W'(DATA_TOP);
   localparam logic [HI_W-1:0] CHECK_LIM = HI_W'(CHECK_TOP);

   logic in_low;
   assign in_low = sym_is_data ? (sym_hi_bit <= DATA_LIM) : (sym_hi_bit <= CHECK_LIM);

   always_comb begin
      if (!correctable) begin
         mask = MASK_BOTH;
         err  = DHR_OK;
      end else if (!sym_ok) begin
         mask = MASK_NONE;
         err  = DHR_BAD_SYM;
      end else begin
         mask = in_low ? MASK_LOW : MASK_UP;
         err  = DHR_OK;
      end
   end
endmodule

// File: rtl/dimm_half_resolver.sv
module dimm_half_resolver
   import dhr_pkg::*;
#(
   parameter int IDX_W     = 6,
   parameter int HI_W      = 8,
   parameter int RES_LSB   = 3,
   parameter int DATA_TOP  = 63,
   parameter int CHECK_TOP = 7,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       dimm_cnt,
   input  logic             ecc_sym,
   input  logic             addr_b3,
   input  logic [IDX_W-1:0] low_valid_idx,
   input  logic             correctable,
   input  logic             sym_ok,
   input  logic             sym_is_data,
   input  logic [HI_W-1:0]  sym_hi_bit,
   output logic             res_valid,
   output logic [1:0]       dimm_mask,
   output logic [1:0]       err_code
);
   logic [1:0] half_mask, sym_mask, nxt_mask;
   dhr_err_e   half_err, sym_err, nxt_err;

   dhr_half_pick #(.IDX_W(IDX_W), .RES_LSB(RES_LSB)) u_half (
      .addr_b3       (addr_b3),
      .low_valid_idx (low_valid_idx),
      .mask          (half_mask),
      .err           (half_err)
   );

   dhr_sym_pick #(.HI_W(HI_W), .DATA_TOP(DATA_TOP), .CHECK_TOP(CHECK_TOP)) u_sym (
      .correctable (correctable),
      .sym_ok      (sym_ok),
      .sym_is_data (sym_is_data),
      .sym_hi_bit  (sym_hi_bit),
      .mask        (sym_mask),
      .err         (sym_err)
   );

   // count decides first, then the ECC organisation
   always_comb begin
      if (!req_valid) begin
         nxt_mask = MASK_NONE;
         nxt_err  = DHR_OK;
      end else if (dimm_cnt == 2'd0) begin
         nxt_mask = MASK_NONE;
         nxt_err  = DHR_NO_DIMM;
      end else if (dimm_cnt == 2'd1) begin
         nxt_mask = MASK_LOW;
         nxt_err  = DHR_OK;
      end else if (ecc_sym) begin
         nxt_mask = sym_mask;
         nxt_err  = sym_err;
      end else begin
         nxt_mask = half_mask;
         nxt_err  = half_err;
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_valid <= 1'b0;
            dimm_mask <= MASK_NONE;
            err_code  <= 2'd0;
         end else begin
            res_valid <= req_valid;
            dimm_mask <= nxt_mask;
            err_code  <= nxt_err;
         end
      end

      p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> res_valid);
      p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> (!res_valid && dimm_mask == 2'b00 && err_code == 2'd0));
      p_no_dimm_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && dimm_cnt == 2'd0) |=> (err_code == 2'd1 && dimm_mask == 2'b00));
      p_single_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && dimm_cnt == 2'd1) |=> (dimm_mask == 2'b01 && err_code == 2'd0));
      p_half_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && dimm_cnt[1] && !ecc_sym && low_valid_idx <= IDX_W'(RES_LSB))
         |=> ($onehot0(dimm_mask) && dimm_mask[1] == $past(addr_b3) && dimm_mask != 2'b00));
      p_uncorr_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && dimm_cnt[1] && ecc_sym && !correctable) |=> (dimm_mask == 2'b11));
   end else begin : g_comb
      assign res_valid = req_valid;
      assign dimm_mask = nxt_mask;
      assign err_code  = nxt_err;
   end

   p_err_mask_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 2'd0) |-> (dimm_mask == 2'b00));
endmodule

// File: tb/test_dimm_half_resolver.sv
module test_dimm_half_resolver;
   localparam int IDX_W = 6;
   localparam int HI_W  = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [1:0]       dimm_cnt = '0;
   logic             ecc_sym = 1'b0;
   logic             addr_b3 = 1'b0;
   logic [IDX_W-1:0] low_valid_idx = '0;
   logic             correctable = 1'b0;
   logic             sym_ok = 1'b0;
   logic             sym_is_data = 1'b0;
   logic [HI_W-1:0]  sym_hi_bit = '0;
   logic             res_valid;
   logic [1:0]       dimm_mask;
   logic [1:0]       err_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dimm_half_resolver i_dimm_half_resolver (
      .clk, .rst_n, .req_valid, .dimm_cnt, .ecc_sym, .addr_b3, .low_valid_idx,
      .correctable, .sym_ok, .sym_is_data, .sym_hi_bit,
      .res_valid, .dimm_mask, .err_code
   );

   task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got v/mask/err=%b expected %b", req, got, exp);
      end
   endtask

   initial begin
      int his[7] = '{0, 7, 8, 63, 64, 127, 255};
      logic [4:0] e;
      string tag;
      repeat (3) @(negedge clk);
      check("R10", {res_valid, dimm_mask, err_code}, 5'b0_00_00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", {res_valid, dimm_mask, err_code}, 5'b0_00_00);
      for (int c = 0; c < 4; c++)
      for (int m = 0; m < 2; m++)
      for (int b = 0; b < 2; b++)
      for (int ix = 0; ix < 8; ix++)
      for (int co = 0; co < 2; co++)
      for (int ok = 0; ok < 2; ok++)
      for (int d = 0; d < 2; d++)
      for (int h = 0; h < 7; h++) begin
         dimm_cnt = 2'(c); ecc_sym = m[0]; addr_b3 = b[0];
         low_valid_idx = IDX_W'(ix); correctable = co[0]; sym_ok = ok[0];
         sym_is_data = d[0]; sym_hi_bit = HI_W'(his[h]);
         req_valid = 1'b1;
         if (c == 0) begin e = 5'b1_00_01; tag = "R1"; end
         else if (c == 1) begin e = 5'b1_01_00; tag = "R2"; end
         else if (m == 0) begin
            if (ix <= 3) begin e = b ? 5'b1_10_00 : 5'b1_01_00; tag = "R3"; end
            else begin e = 5'b1_00_10; tag = "R4/R9"; end
         end else if (co == 0) begin e = 5'b1_11_00; tag = "R6"; end
         else if (ok == 0) begin e = 5'b1_00_11; tag = "R7/R9"; end
         else begin
            e = ((d && his[h] <= 63) || (!d && his[h] <= 7)) ? 5'b1_01_00 : 5'b1_10_00;
            tag = "R5";
         end
         @(negedge clk);
         check(tag, {res_valid, dimm_mask, err_code}, e);
         req_valid = 1'b0;
         @(negedge clk);
         check("R8", {res_valid, dimm_mask, err_code}, 5'b0_00_00);
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #2_000_000;
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule